// File: doc/BRIEF.md
# Load Element Widening Converter

This block sits between the memory return path and the register writeback port of a vector unit. Each transfer carries one raw memory element per lane, a memory-type code and a register-width flag. Every lane turns its raw element into a register-width value: integers are zero- or sign-extended, and half or single precision floats are widened to single or double precision. Elements that already match the register width pass through unchanged. All lanes in a transfer share the same type code, register flag and register count.

Input and output are valid/ready streams with one pipeline register between them. A transfer is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle. The input is ready whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds, and `in_ready` is low. A type pair that the chosen register width cannot take returns zeros and raises `out_err`. So does a load whose total size is too large.

Top module: `ldw_top`

## Requirements
- R1: `in_mtype` codes are 0 U8, 1 U16, 2 U32, 3 U64, 4 S8, 5 S16, 6 S32, 7 S64, 8 F16, 9 F32, 10 F64. Codes 11 to 15 are illegal. With `in_rwide`=1 (64-bit register), codes 0 to 10 are legal. With `in_rwide`=0 (32-bit register), codes 3, 7 and 10 are also illegal.
- R2: Unsigned types are zero-extended from the low bits of each 64-bit lane slice. Raw bits above the element width have no effect on the output.
- R3: Signed types are sign-extended to the register width. With a 32-bit register, bits 63:32 of every output lane are zero.
- R4: Same-width pairs pass the raw element through unchanged: U32, S32 and F32 into a 32-bit register, and U64, S64 and F64 into a 64-bit register.
- R5: A normal F16 becomes an IEEE single for a 32-bit register and an IEEE double for a 64-bit register. A normal F32 becomes a double. The exponent is rebiased and the mantissa is left-aligned.
- R6: A subnormal source is normalized into the wider format. A signed zero stays a zero with the same sign.
- R7: An infinity stays an infinity with the same sign. A NaN keeps an all-ones exponent, and its payload is shifted to the top of the wider mantissa field.
- R8: An illegal pair (R1) sets `out_err`=1 and sets every lane of `out_data` to zero.
- R9: If element bytes (1, 2, 4 or 8) times `in_nreg` exceeds MAX_LOAD_BYTES (16 by default), `out_err`=1 and the output is zero.
- R10: `in_ready` = !`out_valid` || `out_ready`. An accepted transfer shows on the output in the following cycle. Under back-pressure, `out_data` and `out_err` hold.
- R11: While `rst_n` is low, and in the first cycle after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Input transfer accepted when high |
| in_mtype | input | 4 | Memory element type code |
| in_rwide | input | 1 | 1 = 64-bit register, 0 = 32-bit register |
| in_nreg | input | NREG_W (3) | Register count of the load |
| in_data | input | LANES*64 (256) | Raw elements, one 64-bit slice per lane |
| out_valid | output | 1 | Output transfer valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | LANES*64 (256) | Converted values, one 64-bit slice per lane |
| out_err | output | 1 | Illegal pair or oversize load |

## Verification
Every type code is driven with both register widths, using random lanes with random bits above the element. These transfers separate zero extension from sign extension, test the pass-through pairs, check the illegal pairs and show whether upper raw bits leak into the output. Float specials are driven for both widening targets: subnormal extremes, signed zeros, infinities, and quiet and signalling NaNs. These show whether normalization, rebiasing and payload placement are correct. Register counts around the size limit check the oversize error. A long random phase with random output stalls checks hold and acceptance timing against the cycle model.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  localparam logic [3:0] MT_U8  = 4'd0;
  localparam logic [3:0] MT_U16 = 4'd1;
  localparam logic [3:0] MT_U32 = 4'd2;
  localparam logic [3:0] MT_U64 = 4'd3;
  localparam logic [3:0] MT_S8  = 4'd4;
  localparam logic [3:0] MT_S16 = 4'd5;
  localparam logic [3:0] MT_S32 = 4'd6;
  localparam logic [3:0] MT_S64 = 4'd7;
  localparam logic [3:0] MT_F16 = 4'd8;
  localparam logic [3:0] MT_F32 = 4'd9;
  localparam logic [3:0] MT_F64 = 4'd10;

  // log2 of the element size in bytes
  function automatic logic [1:0] elem_size_log2(input logic [3:0] mt);
    case (mt)
      MT_U8, MT_S8:           return 2'd0;
      MT_U16, MT_S16, MT_F16: return 2'd1;
      MT_U32, MT_S32, MT_F32: return 2'd2;
      default:                return 2'd3;
    endcase
  endfunction

  function automatic logic pair_legal(input logic [3:0] mt, input logic wide);
    if (mt > MT_F64) return 1'b0;
    if (!wide && (mt == MT_U64 || mt == MT_S64 || mt == MT_F64)) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/ldw_fp_widen.sv
module ldw_fp_widen #(
  parameter int SE = 5,
  parameter int SM = 10,
  parameter int DE = 8,
  parameter int DM = 23
) (
  input  logic [SE+SM:0] src,
  output logic [DE+DM:0] dst
);
  localparam int BDIFF = (2**(DE-1) - 1) - (2**(SE-1) - 1);
  localparam int LZW   = $clog2(SM + 2);
  localparam int PADW  = DM - SM;

  logic          sgn;
  logic [SE-1:0] exp_in;
  logic [SM-1:0] man_in;
  logic [LZW-1:0] lz;
  logic [SM-1:0] man_norm;
  logic [31:0]   exp_calc;

  assign sgn    = src[SE+SM];
  assign exp_in = src[SE+SM-1:SM];
  assign man_in = src[SM-1:0];

  // leading zeros of the mantissa field; highest set bit wins
  always_comb begin
    lz = LZW'(SM);
    for (int i = 0; i < SM; i++) begin
      if (man_in[i]) lz = LZW'(SM - 1 - i);
    end
  end

  // drop the leading one after normalization
  assign man_norm = man_in << (lz + 1'b1);

  always_comb begin
    exp_calc = '0;
    if (exp_in == '0 && man_in == '0) begin
      dst = {sgn, {DE{1'b0}}, {DM{1'b0}}};
    end else if (exp_in == '0) begin
      exp_calc = 32'(BDIFF) - 32'(lz);
      dst = {sgn, exp_calc[DE-1:0], man_norm, {PADW{1'b0}}};
    end else if (&exp_in) begin
      dst = {sgn, {DE{1'b1}}, man_in, {PADW{1'b0}}};
    end else begin
      exp_calc = 32'(exp_in) + 32'(BDIFF);
      dst = {sgn, exp_calc[DE-1:0], man_in, {PADW{1'b0}}};
    end
  end
endmodule

// File: rtl/ldw_lane.sv
module ldw_lane
  import ldw_pkg::*;
(
  input  logic [63:0] raw,
  input  logic [3:0]  mtype,
  input  logic        wide,
  output logic [63:0] res
);
  logic [31:0] h2s;
  logic [63:0] h2d;
  logic [63:0] s2d;
  logic [63:0] ext;

  ldw_fp_widen #(.SE(5), .SM(10), .DE(8),  .DM(23)) u_h2s (.src(raw[15:0]), .dst(h2s));
  ldw_fp_widen #(.SE(5), .SM(10), .DE(11), .DM(52)) u_h2d (.src(raw[15:0]), .dst(h2d));
  ldw_fp_widen #(.SE(8), .SM(23), .DE(11), .DM(52)) u_s2d (.src(raw[31:0]), .dst(s2d));

  always_comb begin
    case (mtype)
      MT_U8:  ext = {56'd0, raw[7:0]};
      MT_U16: ext = {48'd0, raw[15:0]};
      MT_U32: ext = {32'd0, raw[31:0]};
      MT_S8:  ext = {{56{raw[7]}}, raw[7:0]};
      MT_S16: ext = {{48{raw[15]}}, raw[15:0]};
      MT_S32: ext = {{32{raw[31]}}, raw[31:0]};
      MT_U64, MT_S64, MT_F64: ext = raw;
      MT_F16: ext = wide ? h2d : {32'd0, h2s};
      MT_F32: ext = wide ? s2d : {32'd0, raw[31:0]};
      default: ext = '0;
    endcase
    res = wide ? ext : {32'd0, ext[31:0]};
  end
endmodule

// File: rtl/ldw_ctrl.sv
module ldw_ctrl
  import ldw_pkg::*;
#(
  parameter int NREG_W         = 3,
  parameter int MAX_LOAD_BYTES = 16
) (
  input  logic [3:0]        mtype,
  input  logic              wide,
  input  logic [NREG_W-1:0] nreg,
  output logic              err
);
  logic [31:0] total_bytes;

  assign total_bytes = (32'd1 << elem_size_log2(mtype)) * 32'(nreg);
  assign err = !pair_legal(mtype, wide) || (total_bytes > 32'(MAX_LOAD_BYTES));
endmodule

// File: rtl/ldw_top.sv
module ldw_top #(
  parameter int LANES          = 4,
  parameter int NREG_W         = 3,
  parameter int MAX_LOAD_BYTES = 16,
  localparam int DW            = LANES * 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_mtype,
  input  logic              in_rwide,
  input  logic [NREG_W-1:0] in_nreg,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_err
);
  logic [DW-1:0] conv;
  logic          bad;
  logic          take;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ldw_lane u_lane (
      .raw  (in_data[g*64 +: 64]),
      .mtype(in_mtype),
      .wide (in_rwide),
      .res  (conv[g*64 +: 64])
    );
  end

  ldw_ctrl #(.NREG_W(NREG_W), .MAX_LOAD_BYTES(MAX_LOAD_BYTES)) u_ctrl (
    .mtype(in_mtype),
    .wide (in_rwide),
    .nreg (in_nreg),
    .err  (bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_err   <= bad;
      out_data  <= bad ? '0 : conv;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ldw_chk.sv
module ldw_chk
  import ldw_pkg::*;
#(
  parameter int LANES          = 4,
  parameter int NREG_W         = 3,
  parameter int MAX_LOAD_BYTES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [3:0]            in_mtype,
  input logic                  in_rwide,
  input logic [NREG_W-1:0]     in_nreg,
  input logic [LANES*64-1:0]   in_data,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [LANES*64-1:0]   out_data,
  input logic                  out_err
);
  logic       cap_wide;
  logic [3:0] cap_mt;
  logic       hi_zero;
  logic       u8_zero;
  logic       acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_wide <= 1'b0;
      cap_mt   <= '0;
    end else if (acc) begin
      cap_wide <= in_rwide;
      cap_mt   <= in_mtype;
    end
  end

  always_comb begin
    hi_zero = 1'b1;
    u8_zero = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (out_data[l*64+32 +: 32] != '0) hi_zero = 1'b0;
      if (out_data[l*64+8 +: 56] != '0)  u8_zero = 1'b0;
    end
  end

  // R10
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err));

  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_data == '0);

  // R3
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cap_wide |-> hi_zero);

  // R2
  u8_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_mt == MT_U8 |-> u8_zero);

  // R9
  size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_rwide && in_mtype == MT_U64 && (32'(in_nreg) * 32'd8 > 32'(MAX_LOAD_BYTES))
    |=> out_err);

  // R4
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_rwide && in_mtype == MT_U64 && in_nreg == NREG_W'(1)
    |=> out_data == $past(in_data) && !out_err);
endmodule

bind ldw_top ldw_chk #(.LANES(LANES), .NREG_W(NREG_W), .MAX_LOAD_BYTES(MAX_LOAD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mtype(in_mtype), .in_rwide(in_rwide), .in_nreg(in_nreg), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
);

// File: tb/ldw_top_tb.sv
module ldw_top_tb;
  localparam int LANES  = 4;
  localparam int NREG_W = 3;
  localparam int DW     = LANES * 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [3:0]        in_mtype = '0;
  logic              in_rwide = 1'b0;
  logic [NREG_W-1:0] in_nreg = '0;
  logic [DW-1:0]     in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DW-1:0]     out_data;
  logic              out_err;

  int  nvec = 0;
  int  nfail = 0;
  bit  done = 1'b0;
  bit  rand_bp = 1'b0;

  ldw_top #(.LANES(LANES), .NREG_W(NREG_W), .MAX_LOAD_BYTES(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mtype(in_mtype), .in_rwide(in_rwide), .in_nreg(in_nreg), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
  );

  always #4 clk = ~clk;

  // ---------------- reference conversions ----------------
  function automatic logic [63:0] half_to_double(input logic [15:0] h);
    logic [63:0] b;
    real mag;
    int e = int'(h[14:10]);
    int m = int'(h[9:0]);
    if (e == 31) return {h[15], 11'h7ff, h[9:0], 42'd0};
    if (e == 0) mag = real'(m) * (2.0 ** (-24));
    else        mag = real'(1024 + m) * (2.0 ** (e - 25));
    b = $realtobits(mag);
    b[63] = h[15];
    return b;
  endfunction

  function automatic logic [31:0] half_to_single(input logic [15:0] h);
    logic [63:0] d;
    logic [10:0] de;
    if (h[14:10] == 5'h1f) return {h[15], 8'hff, h[9:0], 13'd0};
    d = half_to_double(h);
    if (d[62:0] == '0) return {d[63], 31'd0};
    de = d[62:52] - 11'd896;
    return {d[63], de[7:0], d[51:29]};
  endfunction

  function automatic logic [63:0] single_to_double(input logic [31:0] s);
    logic [63:0] b;
    real mag;
    int e = int'(s[30:23]);
    int m = int'(s[22:0]);
    if (e == 255) return {s[31], 11'h7ff, s[22:0], 29'd0};
    if (e == 0) mag = real'(m) * (2.0 ** (-149));
    else        mag = real'(8388608 + m) * (2.0 ** (e - 150));
    b = $realtobits(mag);
    b[63] = s[31];
    return b;
  endfunction

  function automatic bit ref_err(input logic [3:0] mt, input logic wide, input logic [NREG_W-1:0] nr);
    int bytes;
    case (mt)
      0, 4:    bytes = 1;
      1, 5, 8: bytes = 2;
      2, 6, 9: bytes = 4;
      default: bytes = 8;
    endcase
    if (mt > 10) return 1'b1;
    if (!wide && (mt == 3 || mt == 7 || mt == 10)) return 1'b1;
    return (bytes * int'(nr)) > 16;
  endfunction

  function automatic logic [63:0] ref_lane(input logic [63:0] raw, input logic [3:0] mt, input logic wide);
    logic [63:0] r;
    longint sv;
    case (mt)
      0: r = 64'(raw[7:0]);
      1: r = 64'(raw[15:0]);
      2: r = 64'(raw[31:0]);
      4: begin sv = longint'($signed(raw[7:0]));  r = sv; end
      5: begin sv = longint'($signed(raw[15:0])); r = sv; end
      6: begin sv = longint'($signed(raw[31:0])); r = sv; end
      3, 7, 10: r = raw;
      8: r = wide ? half_to_double(raw[15:0]) : 64'(half_to_single(raw[15:0]));
      9: r = wide ? single_to_double(raw[31:0]) : 64'(raw[31:0]);
      default: r = '0;
    endcase
    if (!wide) r = r & 64'h0000_0000_ffff_ffff;
    return r;
  endfunction

  function automatic string lane_tag(input logic [63:0] raw, input logic [3:0] mt,
                                     input logic wide, input logic [NREG_W-1:0] nr);
    if (mt > 10 || (!wide && (mt == 3 || mt == 7 || mt == 10))) return "R1/R8";
    if (ref_err(mt, wide, nr)) return "R9";
    if ((wide && (mt == 3 || mt == 7 || mt == 10)) || (!wide && (mt == 2 || mt == 6 || mt == 9)))
      return "R4";
    if (mt <= 2) return "R2";
    if (mt <= 6) return "R3";
    if (mt == 8) begin
      if (raw[14:10] == 5'h1f) return "R7";
      if (raw[14:10] == 5'h00) return "R6";
    end else begin
      if (raw[30:23] == 8'hff) return "R7";
      if (raw[30:23] == 8'h00) return "R6";
    end
    return "R5";
  endfunction

  // ---------------- cycle model ----------------
  logic              m_valid = 1'b0;
  logic [3:0]        m_mt = '0;
  logic              m_wide = 1'b0;
  logic [NREG_W-1:0] m_nr = '0;
  logic [DW-1:0]     m_raw = '0;

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_mt    <= in_mtype;
      m_wide  <= in_rwide;
      m_nr    <= in_nreg;
      m_raw   <= in_data;
    end else if (out_ready) m_valid <= 1'b0;
  end

  always @(negedge clk) begin
    if (!done) begin
      logic exp_rdy;
      exp_rdy = !m_valid || out_ready;
      nvec++;
      if (out_valid !== m_valid || in_ready !== exp_rdy) begin
        nfail++;
        $display("FAIL %s handshake: valid=%b ready=%b expected valid=%b ready=%b",
                 (!rst_n ? "R11" : "R10"), out_valid, in_ready, m_valid, exp_rdy);
      end
      if (m_valid && rst_n) begin
        bit e;
        e = ref_err(m_mt, m_wide, m_nr);
        nvec++;
        if (out_err !== e) begin
          nfail++;
          $display("FAIL %s err: actual=%b expected=%b (mt=%0d wide=%b nreg=%0d)",
                   lane_tag(m_raw[63:0], m_mt, m_wide, m_nr), out_err, e, m_mt, m_wide, m_nr);
        end
        for (int l = 0; l < LANES; l++) begin
          logic [63:0] ex;
          ex = e ? 64'd0 : ref_lane(m_raw[l*64 +: 64], m_mt, m_wide);
          nvec++;
          if (out_data[l*64 +: 64] !== ex) begin
            nfail++;
            $display("FAIL %s lane %0d mt=%0d wide=%b raw=%h: actual=%h expected=%h",
                     lane_tag(m_raw[l*64 +: 64], m_mt, m_wide, m_nr), l, m_mt, m_wide,
                     m_raw[l*64 +: 64], out_data[l*64 +: 64], ex);
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [3:0] mt, input logic wide, input logic [NREG_W-1:0] nr,
                      input logic [DW-1:0] d);
    in_valid = 1'b1;
    in_mtype = mt;
    in_rwide = wide;
    in_nreg  = nr;
    in_data  = d;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] d;
    for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  logic [15:0] hv [12] = '{16'h0001, 16'h03ff, 16'h8200, 16'h7c00,
                           16'hfc00, 16'h7e01, 16'h7d55, 16'h3c00,
                           16'h8000, 16'h7bff, 16'h0400, 16'hc123};
  logic [31:0] sv [8]  = '{32'h0000_0001, 32'h807f_ffff, 32'h7f80_0000, 32'h7fc0_0123,
                           32'h3f80_0000, 32'h8000_0000, 32'h0040_0000, 32'hff7f_ffff};

  initial begin
    forever begin
      @(negedge clk); #1;
      if (rand_bp) out_ready = ($urandom % 10) < 7;
      else out_ready = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired: actual=hung expected=finish");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // every code with both register widths (R1 R2 R3 R4 R8)
    for (int mt = 0; mt < 16; mt++) begin
      for (int w = 0; w < 2; w++) begin
        send(4'(mt), w[0], NREG_W'(1), rnd_data());
        send(4'(mt), w[0], NREG_W'(2), rnd_data());
      end
    end
    // sign bit forced on for signed types (R3)
    d = rnd_data();
    for (int l = 0; l < LANES; l++) d[l*64 +: 64] = d[l*64 +: 64] | 64'h8000_8080_8000_8080;
    for (int mt = 4; mt < 7; mt++) begin
      send(4'(mt), 1'b0, NREG_W'(1), d);
      send(4'(mt), 1'b1, NREG_W'(1), d);
    end
    // half specials (R5 R6 R7)
    for (int p = 0; p < 3; p++) begin
      for (int l = 0; l < LANES; l++) d[l*64 +: 64] = {16'(p), 32'($urandom), hv[p*4 + l]};
      send(4'd8, 1'b0, NREG_W'(1), d);
      send(4'd8, 1'b1, NREG_W'(1), d);
    end
    // single specials (R4 R5 R6 R7)
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < LANES; l++) d[l*64 +: 64] = {32'($urandom), sv[p*4 + l]};
      send(4'd9, 1'b1, NREG_W'(1), d);
      send(4'd9, 1'b0, NREG_W'(1), d);
    end
    // size limit around 16 bytes (R9)
    for (int n = 0; n < 8; n++) begin
      send(4'd3, 1'b1, NREG_W'(n), rnd_data());
      send(4'd2, 1'b1, NREG_W'(n), rnd_data());
      send(4'd1, 1'b0, NREG_W'(n), rnd_data());
    end
    // random traffic under back-pressure (R10)
    rand_bp = 1'b1;
    for (int i = 0; i < 800; i++) begin
      in_valid = 1'b0;
      if (($urandom % 4) == 0) begin
        @(negedge clk); #1;
      end
      send(4'($urandom % 16), 1'($urandom), NREG_W'(($urandom % 3 == 0) ? $urandom : 1), rnd_data());
    end
    in_valid = 1'b0;
    rand_bp = 1'b0;
    repeat (5) @(negedge clk);
    // reset mid-stream (R11)
    in_valid = 1'b1;
    @(negedge clk); #1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule